// File: doc/BRIEF.md
# Segment and Block Address Translator

This block turns a 32-bit effective address into one of two results. If the address lies inside one of the enabled block mappings, the block returns a physical address straight away, and no page lookup is needed for that access. Otherwise it picks one of sixteen segment registers with the top four address bits. It then hands a virtual segment identifier, a 16-bit page index and a 12-bit byte offset to a later page-table stage.

Instruction fetches and data accesses each have their own bank of four block mappings. The block-mapping banks and the segment registers are loaded through a single register write port. That port accepts writes only when the supervisor qualifier is asserted. Each request produces one result in the following cycle. The block match and the segment read run side by side within the same cycle, and a block hit takes priority over the segment path.

Top module: `seg_blk_xlate`

## Requirements
- R1: After reset, every segment register and every block mapping is invalid and `out_valid` is 0. A translation issued right after reset therefore reports a segment fault.
- R2: `out_valid` is 1 exactly in the cycle after a cycle in which `xl_req` was 1. Every result output depends only on the request made in that earlier cycle.
- R3: On the segment path, bits 31:28 select the segment register. `pg_index` carries EA bits 27:12, `pg_offset` carries EA bits 11:0, and `pg_vsid` carries the selected register's 24-bit identifier.
- R4: A block mapping hits when its valid bit is set and `(EA & ~mask) == (ebase & ~mask)`.
- R5: On a block hit, `out_pa` equals `pbase | (EA & mask)` of the chosen mapping, and `out_blk_idx` names that mapping.
- R6: Each valid result asserts exactly one of `out_blk_hit`, `pg_req` and `seg_fault`. A block hit suppresses both the page request and the segment fault.
- R7: When several mappings of the same bank hit, the mapping with the lowest index is used.
- R8: Without a block hit, an invalid selected segment register gives `seg_fault=1` and `pg_req=0`. A valid one gives `pg_req=1`.
- R9: A register write takes effect only when `cfg_we` and `cfg_super` are both 1. Writes with `cfg_super=0`, writes to block index 4 or above, and writes to space 3 change nothing.
- R10: A write takes effect for requests issued in the cycle after the write cycle. A request issued in the same cycle as the write still sees the old contents.
- R11: Requests with `xl_is_inst=1` match only the instruction bank, and all other requests match only the data bank.
- R12: The write port is organised as follows.
  - `cfg_space` selects the target: 0 = segment register, 1 = instruction bank, 2 = data bank.
  - For a segment register, `cfg_wdata[31]` is the valid bit and `cfg_wdata[23:0]` is the identifier.
  - For a block mapping, `cfg_field` selects the target field: 0 = effective base, 1 = mask, 2 = physical base, 3 = valid, where the valid bit is taken from `cfg_wdata[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_super | input | 1 | Supervisor qualifier for writes |
| cfg_space | input | 2 | Write target space |
| cfg_idx | input | 4 | Segment or mapping index |
| cfg_field | input | 2 | Block mapping field select |
| cfg_wdata | input | 32 | Write data |
| xl_req | input | 1 | Translation request |
| xl_ea | input | 32 | Effective address |
| xl_is_inst | input | 1 | 1 = instruction fetch, 0 = data access |
| out_valid | output | 1 | Result valid |
| out_blk_hit | output | 1 | Block mapping hit |
| out_blk_idx | output | 2 | Index of the hitting mapping |
| out_pa | output | 32 | Physical address on a block hit |
| pg_req | output | 1 | Page lookup request |
| pg_vsid | output | 24 | Virtual segment identifier |
| pg_index | output | 16 | Page index |
| pg_offset | output | 12 | Byte offset |
| seg_fault | output | 1 | Selected segment invalid |

## Verification
A corrupted segment register shows up in the next cycle, either as a wrong `pg_vsid` or as a wrong choice between a fault and a page request. That happens on the first request that selects the segment, so the bench sweeps every segment with several addresses. A wrong mapping field or a wrong priority choice shows as a wrong `out_pa` or `out_blk_idx`, or as a missing hit. To expose these, overlapping mappings and addresses at the region edges are swept for both access kinds. Write-timing faults appear only when a write and a request share a cycle, so the bench pairs them on purpose.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int EA_W      = 32;
  localparam int SEG_SEL_W = 4;
  localparam int OFF_W     = 12;
  localparam int PIDX_W    = EA_W - SEG_SEL_W - OFF_W;
  localparam int SEG_N     = 1 << SEG_SEL_W;
  localparam int VSID_W    = 24;
  localparam int BLK_N     = 4;
  localparam int BLK_IDX_W = $clog2(BLK_N);
  localparam int SEG_VALID_BIT = EA_W - 1;

  typedef enum logic [1:0] {
    SPC_SEG  = 2'd0,
    SPC_IBLK = 2'd1,
    SPC_DBLK = 2'd2,
    SPC_RSVD = 2'd3
  } cfg_space_e;

  typedef enum logic [1:0] {
    FLD_EBASE = 2'd0,
    FLD_MASK  = 2'd1,
    FLD_PBASE = 2'd2,
    FLD_VALID = 2'd3
  } blk_field_e;

  typedef struct packed {
    logic            valid;
    logic [EA_W-1:0] ebase;
    logic [EA_W-1:0] emask;
    logic [EA_W-1:0] pbase;
  } blk_entry_t;

  typedef struct packed {
    logic              valid;
    logic [VSID_W-1:0] vsid;
  } seg_entry_t;

  function automatic logic blk_covers(input logic [EA_W-1:0] ea,
                                      input logic [EA_W-1:0] base,
                                      input logic [EA_W-1:0] mask);
    return (ea & ~mask) == (base & ~mask);
  endfunction

  function automatic logic [EA_W-1:0] blk_phys(input logic [EA_W-1:0] ea,
                                               input logic [EA_W-1:0] pbase,
                                               input logic [EA_W-1:0] mask);
    return pbase | (ea & mask);
  endfunction

  function automatic logic [SEG_SEL_W-1:0] seg_select(input logic [EA_W-1:0] ea);
    return ea[EA_W-1 -: SEG_SEL_W];
  endfunction

  function automatic logic [PIDX_W-1:0] page_index(input logic [EA_W-1:0] ea);
    return ea[OFF_W +: PIDX_W];
  endfunction

  function automatic logic [OFF_W-1:0] page_offset(input logic [EA_W-1:0] ea);
    return ea[OFF_W-1:0];
  endfunction
endpackage

// File: rtl/xlate_seg_file.sv
module xlate_seg_file #(
  parameter int N_ENT  = 16,
  parameter int ID_W   = 24,
  parameter int IDX_W  = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [ID_W-1:0]  wr_id,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [ID_W-1:0]  rd_id
);
  logic            ent_valid [N_ENT];
  logic [ID_W-1:0] ent_id    [N_ENT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic hit_wr;
    assign hit_wr = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_valid[g] <= 1'b0;
        ent_id[g]    <= '0;
      end else if (hit_wr) begin
        ent_valid[g] <= wr_valid;
        ent_id[g]    <= wr_id;
      end
    end
  end

  assign rd_valid = ent_valid[rd_idx];
  assign rd_id    = ent_id[rd_idx];
endmodule

// File: rtl/xlate_blk_bank.sv
module xlate_blk_bank
  import xlate_pkg::*;
#(
  parameter int N_ENT = 4,
  parameter int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_field,
  input  logic [EA_W-1:0]  wr_data,
  input  logic [EA_W-1:0]  ea,
  output logic [N_ENT-1:0] hit_vec,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic [EA_W-1:0]  hit_pa
);
  blk_entry_t ent [N_ENT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent[g] <= '0;
      end else if (sel) begin
        case (blk_field_e'(wr_field))
          FLD_EBASE: ent[g].ebase <= wr_data;
          FLD_MASK:  ent[g].emask <= wr_data;
          FLD_PBASE: ent[g].pbase <= wr_data;
          FLD_VALID: ent[g].valid <= wr_data[0];
          default:   ent[g].valid <= ent[g].valid;
        endcase
      end
    end
    assign hit_vec[g] = ent[g].valid && blk_covers(ea, ent[g].ebase, ent[g].emask);
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    hit_pa  = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
        hit_pa  = blk_phys(ea, ent[i].pbase, ent[i].emask);
      end
    end
  end
endmodule

// File: rtl/seg_blk_xlate.sv
module seg_blk_xlate
  import xlate_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic                 cfg_super,
  input  logic [1:0]           cfg_space,
  input  logic [SEG_SEL_W-1:0] cfg_idx,
  input  logic [1:0]           cfg_field,
  input  logic [EA_W-1:0]      cfg_wdata,
  input  logic                 xl_req,
  input  logic [EA_W-1:0]      xl_ea,
  input  logic                 xl_is_inst,
  output logic                 out_valid,
  output logic                 out_blk_hit,
  output logic [BLK_IDX_W-1:0] out_blk_idx,
  output logic [EA_W-1:0]      out_pa,
  output logic                 pg_req,
  output logic [VSID_W-1:0]    pg_vsid,
  output logic [PIDX_W-1:0]    pg_index,
  output logic [OFF_W-1:0]     pg_offset,
  output logic                 seg_fault
);
  // Named internal events for the checker
  logic                 ev_cfg_accept;
  logic                 ev_blk_hit;
  logic                 ev_seg_fault;
  logic                 ev_page_req;
  logic [BLK_N-1:0]     ev_hit_vec;
  logic [BLK_IDX_W-1:0] ev_hit_idx;

  logic blk_idx_ok;
  logic wr_seg, wr_iblk, wr_dblk;

  assign ev_cfg_accept = cfg_we && cfg_super;
  assign blk_idx_ok    = int'(cfg_idx) < BLK_N;
  assign wr_seg  = ev_cfg_accept && (cfg_space_e'(cfg_space) == SPC_SEG);
  assign wr_iblk = ev_cfg_accept && (cfg_space_e'(cfg_space) == SPC_IBLK) && blk_idx_ok;
  assign wr_dblk = ev_cfg_accept && (cfg_space_e'(cfg_space) == SPC_DBLK) && blk_idx_ok;

  logic              seg_valid;
  logic [VSID_W-1:0] seg_vsid;

  xlate_seg_file #(.N_ENT(SEG_N), .ID_W(VSID_W), .IDX_W(SEG_SEL_W)) u_seg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_seg),
    .wr_idx   (cfg_idx),
    .wr_valid (cfg_wdata[SEG_VALID_BIT]),
    .wr_id    (cfg_wdata[VSID_W-1:0]),
    .rd_idx   (seg_select(xl_ea)),
    .rd_valid (seg_valid),
    .rd_id    (seg_vsid)
  );

  logic [BLK_N-1:0]     bk_vec [2];
  logic                 bk_hit [2];
  logic [BLK_IDX_W-1:0] bk_idx [2];
  logic [EA_W-1:0]      bk_pa  [2];
  logic                 bk_wr  [2];

  assign bk_wr[0] = wr_iblk;
  assign bk_wr[1] = wr_dblk;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    xlate_blk_bank #(.N_ENT(BLK_N), .IDX_W(BLK_IDX_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bk_wr[b]),
      .wr_idx   (cfg_idx[BLK_IDX_W-1:0]),
      .wr_field (cfg_field),
      .wr_data  (cfg_wdata),
      .ea       (xl_ea),
      .hit_vec  (bk_vec[b]),
      .hit      (bk_hit[b]),
      .hit_idx  (bk_idx[b]),
      .hit_pa   (bk_pa[b])
    );
  end

  logic bank_sel;
  assign bank_sel    = !xl_is_inst;
  assign ev_hit_vec  = bk_vec[bank_sel];
  assign ev_hit_idx  = bk_idx[bank_sel];
  assign ev_blk_hit  = xl_req && bk_hit[bank_sel];
  assign ev_seg_fault = xl_req && !bk_hit[bank_sel] && !seg_valid;
  assign ev_page_req  = xl_req && !bk_hit[bank_sel] && seg_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_blk_hit <= 1'b0;
      out_blk_idx <= '0;
      out_pa      <= '0;
      pg_req      <= 1'b0;
      pg_vsid     <= '0;
      pg_index    <= '0;
      pg_offset   <= '0;
      seg_fault   <= 1'b0;
    end else begin
      out_valid   <= xl_req;
      out_blk_hit <= ev_blk_hit;
      out_blk_idx <= ev_blk_hit ? ev_hit_idx : '0;
      out_pa      <= ev_blk_hit ? bk_pa[bank_sel] : '0;
      pg_req      <= ev_page_req;
      seg_fault   <= ev_seg_fault;
      pg_vsid     <= seg_vsid;
      pg_index    <= page_index(xl_ea);
      pg_offset   <= page_offset(xl_ea);
    end
  end
endmodule

// File: rtl/xlate_chk.sv
module xlate_chk
  import xlate_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 xl_req,
  input logic [EA_W-1:0]      xl_ea,
  input logic                 out_valid,
  input logic                 out_blk_hit,
  input logic                 pg_req,
  input logic                 seg_fault,
  input logic [PIDX_W-1:0]    pg_index,
  input logic [OFF_W-1:0]     pg_offset,
  input logic                 ev_blk_hit,
  input logic [BLK_N-1:0]     ev_hit_vec,
  input logic [BLK_IDX_W-1:0] ev_hit_idx
);
  logic [OFF_W-1:0]  ea_off;
  logic [PIDX_W-1:0] ea_pidx;
  assign ea_off  = xl_ea[OFF_W-1:0];
  assign ea_pidx = xl_ea[OFF_W +: PIDX_W];

  // R2: a result follows every request by one cycle
  assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xl_req |=> out_valid);
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_req |=> !out_valid);

  // R6: exactly one outcome per valid result
  assert_one_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({out_blk_hit, pg_req, seg_fault}) == 1);
  assert_quiet_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(out_blk_hit || pg_req || seg_fault));

  // R3: page fields come from the request address
  assert_page_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xl_req |=> (pg_offset == $past(ea_off)) && (pg_index == $past(ea_pidx)));

  // R7: chosen mapping is the lowest hitting one
  assert_lowest_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_blk_hit |-> ev_hit_vec[ev_hit_idx] &&
      ((ev_hit_vec & ((BLK_N'(1) << ev_hit_idx) - BLK_N'(1))) == '0));

  // R4: a hit is only reported when some mapping matched
  assert_hit_needs_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_blk_hit |-> ev_hit_vec != '0);
endmodule

bind seg_blk_xlate xlate_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .xl_req      (xl_req),
  .xl_ea       (xl_ea),
  .out_valid   (out_valid),
  .out_blk_hit (out_blk_hit),
  .pg_req      (pg_req),
  .seg_fault   (seg_fault),
  .pg_index    (pg_index),
  .pg_offset   (pg_offset),
  .ev_blk_hit  (ev_blk_hit),
  .ev_hit_vec  (ev_hit_vec),
  .ev_hit_idx  (ev_hit_idx)
);

// File: tb/seg_blk_xlate_tb_top.sv
`timescale 1ns/1ps
module seg_blk_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_super = 1'b0;
  logic [1:0]  cfg_space = '0, cfg_field = '0;
  logic [3:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        xl_req = 1'b0, xl_is_inst = 1'b0;
  logic [31:0] xl_ea = '0;
  logic        out_valid, out_blk_hit, pg_req, seg_fault;
  logic [1:0]  out_blk_idx;
  logic [31:0] out_pa;
  logic [23:0] pg_vsid;
  logic [15:0] pg_index;
  logic [11:0] pg_offset;

  always #2.5 clk = ~clk;

  seg_blk_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_super(cfg_super),
    .cfg_space(cfg_space), .cfg_idx(cfg_idx), .cfg_field(cfg_field),
    .cfg_wdata(cfg_wdata), .xl_req(xl_req), .xl_ea(xl_ea),
    .xl_is_inst(xl_is_inst), .out_valid(out_valid), .out_blk_hit(out_blk_hit),
    .out_blk_idx(out_blk_idx), .out_pa(out_pa), .pg_req(pg_req),
    .pg_vsid(pg_vsid), .pg_index(pg_index), .pg_offset(pg_offset),
    .seg_fault(seg_fault)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Bench-side model of the register state
  logic        m_sv  [16];
  logic [23:0] m_sid [16];
  logic        m_bv  [2][4];
  logic [31:0] m_bb  [2][4];
  logic [31:0] m_bm  [2][4];
  logic [31:0] m_bp  [2][4];

  task automatic cmp(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One cycle: optional request and optional write in the same cycle.
  task automatic step(input logic req, input logic [31:0] ea, input logic inst,
                      input logic we, input logic sup, input logic [1:0] sp,
                      input logic [3:0] idx, input logic [1:0] fld,
                      input logic [31:0] wd, input string tag);
    logic        e_hit = 1'b0, e_pg = 1'b0, e_flt = 1'b0;
    logic [1:0]  e_idx = '0;
    logic [31:0] e_pa = '0;
    int          bk = inst ? 0 : 1;
    int          sg = int'(ea >> 28);
    if (req) begin
      for (int i = 3; i >= 0; i--) begin
        if (m_bv[bk][i] && (((ea ^ m_bb[bk][i]) & ~m_bm[bk][i]) == 32'h0)) begin
          e_hit = 1'b1; e_idx = 2'(i); e_pa = m_bp[bk][i] | (ea & m_bm[bk][i]);
        end
      end
      if (!e_hit) begin
        e_pg  = m_sv[sg];
        e_flt = !m_sv[sg];
      end
    end
    xl_req = req; xl_ea = ea; xl_is_inst = inst;
    cfg_we = we; cfg_super = sup; cfg_space = sp; cfg_idx = idx;
    cfg_field = fld; cfg_wdata = wd;
    @(posedge clk);
    #1;
    if (we && sup) begin
      if (sp == 2'd0) begin
        m_sv[idx] = wd[31]; m_sid[idx] = wd[23:0];
      end else if ((sp == 2'd1 || sp == 2'd2) && idx < 4) begin
        case (fld)
          2'd0: m_bb[sp-1][idx] = wd;
          2'd1: m_bm[sp-1][idx] = wd;
          2'd2: m_bp[sp-1][idx] = wd;
          default: m_bv[sp-1][idx] = wd[0];
        endcase
      end
    end
    @(negedge clk);
    xl_req = 1'b0; cfg_we = 1'b0;
    cmp(tag, "out_valid (R2)", 32'(out_valid), 32'(req));
    if (req) begin
      cmp(tag, "out_blk_hit (R4/R6)", 32'(out_blk_hit), 32'(e_hit));
      cmp(tag, "pg_req (R8)", 32'(pg_req), 32'(e_pg));
      cmp(tag, "seg_fault (R8)", 32'(seg_fault), 32'(e_flt));
      if (e_hit) begin
        cmp(tag, "out_pa (R5)", out_pa, e_pa);
        cmp(tag, "out_blk_idx (R7)", 32'(out_blk_idx), 32'(e_idx));
      end
      if (e_pg) begin
        cmp(tag, "pg_vsid (R3)", 32'(pg_vsid), 32'(m_sid_pre(sg, e_pg)));
        cmp(tag, "pg_index (R3)", 32'(pg_index), (ea / 32'h1000) % 32'h10000);
        cmp(tag, "pg_offset (R3)", 32'(pg_offset), ea % 32'h1000);
      end
    end
  endtask

  // Identifier captured before the cycle's write: stored separately per step.
  logic [23:0] snap_sid [16];
  function automatic logic [23:0] m_sid_pre(input int sg, input logic unused);
    return snap_sid[sg];
  endfunction

  task automatic xl(input logic [31:0] ea, input logic inst, input string tag);
    for (int s = 0; s < 16; s++) snap_sid[s] = m_sid[s];
    step(1'b1, ea, inst, 1'b0, 1'b0, 2'd0, 4'd0, 2'd0, 32'h0, tag);
  endtask

  task automatic wr(input logic sup, input logic [1:0] sp, input logic [3:0] idx,
                    input logic [1:0] fld, input logic [31:0] wd, input string tag);
    for (int s = 0; s < 16; s++) snap_sid[s] = m_sid[s];
    step(1'b0, 32'h0, 1'b0, 1'b1, sup, sp, idx, fld, wd, tag);
  endtask

  task automatic blk(input logic [1:0] sp, input logic [3:0] idx, input logic [31:0] b,
                     input logic [31:0] m, input logic [31:0] p);
    wr(1'b1, sp, idx, 2'd0, b, "R12");
    wr(1'b1, sp, idx, 2'd1, m, "R12");
    wr(1'b1, sp, idx, 2'd2, p, "R12");
    wr(1'b1, sp, idx, 2'd3, 32'h1, "R12");
  endtask

  initial begin
    for (int s = 0; s < 16; s++) begin m_sv[s] = 1'b0; m_sid[s] = '0; snap_sid[s] = '0; end
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 4; i++) begin
        m_bv[b][i] = 1'b0; m_bb[b][i] = '0; m_bm[b][i] = '0; m_bp[b][i] = '0;
      end
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R1", "out_valid in reset", 32'(out_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: everything invalid after reset
    xl(32'h3000_1234, 1'b0, "R1");
    xl(32'h0000_0000, 1'b1, "R1");

    // R9: writes without supervisor or to bad targets are ignored
    wr(1'b0, 2'd0, 4'd3, 2'd0, 32'h8012_3456, "R9");
    xl(32'h3ABC_D123, 1'b0, "R9");
    wr(1'b0, 2'd1, 4'd0, 2'd3, 32'h1, "R9");
    xl(32'h0000_0010, 1'b1, "R9");
    wr(1'b1, 2'd3, 4'd2, 2'd3, 32'h8000_0001, "R9");
    xl(32'h2000_0010, 1'b0, "R9");

    // R3/R8/R12: load all segments, last one left invalid, sweep
    for (int s = 0; s < 16; s++)
      wr(1'b1, 2'd0, 4'(s), 2'd0,
         {(s != 15), 7'h0, 24'h100000 ^ 24'(s * 24'h13579)}, "R12");
    for (int s = 0; s < 16; s++)
      for (int k = 0; k < 8; k++)
        xl({4'(s), 16'(k * 16'h2491 ^ s), 12'(k * 12'h1A3 + s)}, k[0], "R3_R8");
    xl(32'hFFFF_FFFF, 1'b0, "R3_R8");
    xl(32'h0000_0000, 1'b0, "R3_R8");

    // R4/R5/R7/R11: overlapping mappings; index 4+ write ignored (R9)
    blk(2'd1, 4'd1, 32'h1000_0000, 32'h00FF_FFFF, 32'h9000_0000);
    blk(2'd1, 4'd0, 32'h1003_0000, 32'h0001_FFFF, 32'h8000_0000);
    blk(2'd2, 4'd0, 32'h2000_0000, 32'h000F_FFFF, 32'hA000_0000);
    blk(2'd2, 4'd3, 32'h1000_0000, 32'h0000_FFFF, 32'hC000_0000);
    blk(2'd2, 4'd5, 32'h5000_0000, 32'h0FFF_FFFF, 32'hE000_0000);
    for (int k = 0; k < 40; k++) begin
      xl(32'h1000_0000 + 32'(k) * 32'h0000_8000 + 32'(k * 19), 1'b1, "R4_R7_R11");
      xl(32'h1000_0000 + 32'(k) * 32'h0000_8000 + 32'(k * 19), 1'b0, "R4_R11");
      xl(32'h2000_0000 + 32'(k) * 32'h0000_8000 + 32'(k * 7), 1'b0, "R5_R11");
      xl(32'h2000_0000 + 32'(k) * 32'h0000_8000, 1'b1, "R11");
    end
    xl(32'h1000_FFFF, 1'b0, "R4");
    xl(32'h1001_0000, 1'b0, "R4");
    xl(32'h10FF_FFFF, 1'b1, "R4");
    xl(32'h1100_0000, 1'b1, "R4");
    xl(32'h5000_0000, 1'b0, "R9");

    // R10: write and request in the same cycle see the old state
    for (int s = 0; s < 16; s++) snap_sid[s] = m_sid[s];
    step(1'b1, 32'h6000_5ABC, 1'b0, 1'b1, 1'b1, 2'd0, 4'd6, 2'd0, 32'h80AB_CDEF, "R10");
    xl(32'h6000_5ABC, 1'b0, "R10");
    for (int s = 0; s < 16; s++) snap_sid[s] = m_sid[s];
    step(1'b1, 32'h1003_0040, 1'b1, 1'b1, 1'b1, 2'd1, 4'd0, 2'd3, 32'h0, "R10");
    xl(32'h1003_0040, 1'b1, "R10");
    for (int s = 0; s < 16; s++) snap_sid[s] = m_sid[s];
    step(1'b1, 32'h7000_0000, 1'b1, 1'b1, 1'b1, 2'd0, 4'd7, 2'd0, 32'h0000_0001, "R10");
    xl(32'h7000_0000, 1'b1, "R10");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule